// File: doc/BRIEF.md
# I2C Controller Byte Transmitter

This block is the transmit side of an I2C bus controller. On a start request it pulls SDA low while SCL is high to issue a START. It then shifts out the address byte taken from the host data bus. Each byte is followed by a ninth clock, during which SDA is released so the target can acknowledge. The level on SDA at the rising edge of that ninth clock sets a status flag.

At the falling edge of the ninth clock the block raises a one-cycle interrupt, whether the target acknowledged or not. It then parks with SCL held low. The host answers in one of two ways: a byte write loads the next byte and releases the clock, or a stop request produces a STOP and returns the engine to idle. Bit timing comes from a divider input that sets the length of every SCL phase.

Both bus lines are open-drain. The block outputs pull-low enables and reads the resolved SDA level back.

Top module: `i2c_byte_tx`

## Requirements
- R1: In idle, a start_req pulse captures wr_data as the address byte. SDA is pulled low while SCL stays released for div+1 clocks, and then SCL is pulled low for the first bit.
- R2: Each byte is sent MSB first as eight SCL pulses. SDA changes only while SCL is pulled low, except at START and STOP.
- R3: Within a byte, every SCL released phase lasts div+1 clocks, and every SCL low phase between two bits lasts div+1 clocks.
- R4: During the ninth clock SDA is released. ack_det takes the value 1 when sda_in is low, and 0 when it is high, at the moment SCL is released for the ninth clock.
- R5: ack_det reads 0 from the first low phase of each new byte until the ninth clock's sample.
- R6: irq is a single-cycle pulse that appears together with the SCL fall ending the ninth clock, once per byte, for ACK and NACK alike. irq_is_addr reads 1 with it for the address byte and 0 for data bytes.
- R7: After the ninth clock, SCL stays pulled low for as long as neither wr_en nor stop_req is asserted.
- R8: While parked, wr_en loads wr_data and starts sending it. wr_en in idle or during a byte, and start_req while busy, have no effect on the bus.
- R9: stop_req while parked pulls SDA low with SCL low for one phase, then releases SCL for one phase, then releases SDA while SCL is high, and busy drops. stop_req wins over a wr_en in the same cycle.
- R10: After reset and in idle, both lines are released, and busy, irq and ack_det read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div | input | DIV_W | SCL phase length minus one, in clocks |
| start_req | input | 1 | Begin a transfer with wr_data as the address |
| stop_req | input | 1 | End the transfer while parked |
| wr_en | input | 1 | Load wr_data and release the parked clock |
| wr_data | input | 8 | Byte to send |
| sda_in | input | 1 | Resolved SDA level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| ack_det | output | 1 | Last ninth-clock sample, 1 = ACK |
| irq | output | 1 | End-of-byte pulse |
| irq_is_addr | output | 1 | Last finished byte was the address |
| busy | output | 1 | Engine not idle |

## Verification
The assertions watch every cycle for several properties. They check that the interrupt is a lone pulse landing in the parked state and that SDA stays still during SCL high phases of data bits. They also check that SDA is released over the whole ninth clock, that the acknowledge flag is clear at the first bit of a byte, and that a parked engine keeps SCL low. Stop priority and released lines in idle are covered as well. Only the bench scenarios can show the rest. A bus-level target model decodes the bytes and measures phase lengths and the START hold, and it drives ACK or NACK at random. Those scenarios confirm that stray writes and start requests leave the transmitted bytes unchanged and that the STOP edge appears on the wire.

// File: rtl/i2c_byte_tx.sv
module i2c_byte_tx #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             sda_in,
  output logic             scl_pull,
  output logic             sda_pull,
  output logic             ack_det,
  output logic             irq,
  output logic             irq_is_addr,
  output logic             busy
);
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_LOW, S_HIGH, S_WAIT, S_STP_A, S_STP_B, S_STP_C
  } st_t;

  st_t             st;
  logic [DIV_W-1:0] cnt;
  logic [3:0]      bitn;
  logic [7:0]      sh;
  logic            addr_byte;

  wire done  = (cnt == div);
  wire ninth = (bitn == 4'd8);
  wire timed = (st != S_IDLE) && (st != S_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      bitn        <= '0;
      sh          <= '0;
      addr_byte   <= 1'b0;
      ack_det     <= 1'b0;
      irq         <= 1'b0;
      irq_is_addr <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (!timed || done) cnt <= '0;
      else                cnt <= cnt + 1'b1;
      case (st)
        S_IDLE: if (start_req) begin
          st        <= S_START;
          sh        <= wr_data;
          addr_byte <= 1'b1;
        end
        S_START: if (done) begin
          st      <= S_LOW;
          bitn    <= '0;
          ack_det <= 1'b0;
        end
        S_LOW: if (done) begin
          st <= S_HIGH;
          if (ninth) ack_det <= ~sda_in;
        end
        S_HIGH: if (done) begin
          if (ninth) begin
            st          <= S_WAIT;
            irq         <= 1'b1;
            irq_is_addr <= addr_byte;
          end else begin
            st   <= S_LOW;
            bitn <= bitn + 4'd1;
            sh   <= {sh[6:0], 1'b0};
          end
        end
        S_WAIT: if (stop_req) begin
          st <= S_STP_A;
        end else if (wr_en) begin
          st        <= S_LOW;
          bitn      <= '0;
          sh        <= wr_data;
          addr_byte <= 1'b0;
          ack_det   <= 1'b0;
        end
        S_STP_A: if (done) st <= S_STP_B;
        S_STP_B: if (done) st <= S_STP_C;
        S_STP_C: if (done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign scl_pull = (st == S_LOW) || (st == S_WAIT) || (st == S_STP_A);
  assign sda_pull = (st == S_START) || (st == S_STP_A) || (st == S_STP_B) ||
                    (((st == S_LOW) || (st == S_HIGH)) && !ninth && !sh[7]);
  assign busy     = (st != S_IDLE);
endmodule

// File: rtl/i2c_byte_tx_chk.sv
module i2c_byte_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] st,
  input logic [3:0] bitn,
  input logic       stop_req,
  input logic       wr_en,
  input logic       scl_pull,
  input logic       sda_pull,
  input logic       ack_det,
  input logic       irq,
  input logic       busy
);
  localparam logic [2:0] LOW = 3'd2, HIGH = 3'd3, WAIT = 3'd4, STPA = 3'd5;

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  // R6
  irq_wait_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (st == WAIT && scl_pull));
  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WAIT && !stop_req && !wr_en) |=> (scl_pull && !irq && busy));
  // R4
  ack_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == LOW || st == HIGH) && bitn == 4'd8) |-> !sda_pull);
  // R2
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HIGH && $past(st) == HIGH) |-> $stable(sda_pull));
  // R5
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LOW && bitn == 4'd0) |-> !ack_det);
  // R10
  idle_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_pull && !sda_pull && !irq));
  // R9
  stop_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WAIT && stop_req) |=> (st == STPA && sda_pull && scl_pull));
endmodule

bind i2c_byte_tx i2c_byte_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .bitn(bitn), .stop_req(stop_req),
  .wr_en(wr_en), .scl_pull(scl_pull), .sda_pull(sda_pull),
  .ack_det(ack_det), .irq(irq), .busy(busy)
);

// File: tb/sim_i2c_byte_tx.sv
module sim_i2c_byte_tx;
  localparam int DIV_W = 8;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start_req, stop_req, wr_en, sda_in;
  logic [DIV_W-1:0] div;
  logic [7:0] wr_data;
  logic scl_pull, sda_pull, ack_det, irq, irq_is_addr, busy;

  logic ack_en = 1'b0, pull = 1'b0;
  assign sda_in = ~(sda_pull | pull);

  i2c_byte_tx #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .div(div), .start_req(start_req), .stop_req(stop_req),
    .wr_en(wr_en), .wr_data(wr_data), .sda_in(sda_in), .scl_pull(scl_pull),
    .sda_pull(sda_pull), .ack_det(ack_det), .irq(irq), .irq_is_addr(irq_is_addr), .busy(busy)
  );

  int checks = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bus-level target model and monitor
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  int rise_cnt = 0, hi_len = 0, lo_len = 0, st_len = 0, start_len = 0;
  bit in_start = 0;
  int irq_cnt = 0, hi_err = 0, lo_err = 0, stop_cnt = 0, start_cnt = 0;
  logic [7:0] byte_sh = 0, rx_byte = 0;

  always @(negedge clk) begin
    logic sclv, sdav;
    sclv = ~scl_pull;
    sdav = sda_in;
    if (irq) irq_cnt++;
    if (prev_scl && sclv && prev_sda && !sdav) begin
      rise_cnt = 0; in_start = 1; st_len = 1; start_cnt++;
    end else if (prev_scl && sclv && !prev_sda && sdav) begin
      stop_cnt++;
    end else if (in_start && sclv) begin
      st_len++;
    end
    if (!prev_scl && sclv) begin
      if (rise_cnt >= 1 && rise_cnt <= 8 && lo_len != int'(div) + 1) lo_err++;
      rise_cnt++; hi_len = 1;
      if (rise_cnt <= 8) byte_sh = {byte_sh[6:0], sdav};
    end else if (prev_scl && sclv) begin
      hi_len++;
    end
    if (prev_scl && !sclv) begin
      lo_len = 1;
      if (in_start) begin start_len = st_len; in_start = 0; end
      if (rise_cnt >= 1 && hi_len != int'(div) + 1) hi_err++;
      if (rise_cnt == 9) begin rx_byte = byte_sh; rise_cnt = 0; end
    end else if (!sclv) begin
      lo_len++;
    end
    pull <= ack_en && ((rise_cnt == 8 && !sclv) || rise_cnt == 9);
    prev_scl = sclv;
    prev_sda = sdav;
  end

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 20000) begin @(negedge clk); n++; end
    chk(irq === 1'b1, req, irq, 1);
  endtask

  task automatic xfer(input logic [7:0] addr, input int nd, input logic [DIV_W-1:0] d,
                      input bit noise, input bit both, input bit force_nack);
    int ib, he, le, sc;
    logic [7:0] dat;
    bit ea;
    ib = irq_cnt; he = hi_err; le = lo_err; sc = stop_cnt;
    div = d;
    ea = force_nack ? 1'b0 : ($urandom % 4 != 0);
    ack_en = ea;
    @(negedge clk); start_req = 1; wr_data = addr;
    @(negedge clk); start_req = 0; wr_data = ~addr;
    if (noise) begin
      repeat (int'(d) + 3) @(negedge clk);
      wr_en = 1; start_req = 1;
      @(negedge clk); wr_en = 0; start_req = 0;
    end
    wait_irq("R6 addr irq");
    chk(irq_is_addr === 1'b1, "R6 addr flag", irq_is_addr, 1);
    chk(ack_det === ea, "R4 addr ack", ack_det, ea);
    @(negedge clk);
    chk(rx_byte === addr, noise ? "R8 addr byte" : "R2 addr byte", rx_byte, addr);
    chk(start_len == int'(d) + 1, "R1 start hold", start_len, int'(d) + 1);
    for (int k = 0; k < nd; k++) begin
      repeat ($urandom % 20) @(negedge clk);
      chk(scl_pull === 1'b1 && busy === 1'b1, "R7 parked", scl_pull, 1);
      dat = 8'($urandom);
      ea = $urandom % 3 != 0;
      ack_en = ea;
      wr_en = 1; wr_data = dat;
      @(negedge clk); wr_en = 0; wr_data = ~dat;
      chk(ack_det === 1'b0, "R5 ack cleared", ack_det, 0);
      if (noise) begin
        wr_en = 1; @(negedge clk); wr_en = 0;
      end
      wait_irq("R6 data irq");
      chk(irq_is_addr === 1'b0, "R6 data flag", irq_is_addr, 0);
      chk(ack_det === ea, "R4 data ack", ack_det, ea);
      @(negedge clk);
      chk(rx_byte === dat, noise ? "R8 data byte" : "R2 data byte", rx_byte, dat);
    end
    repeat ($urandom % 5) @(negedge clk);
    stop_req = 1; wr_en = both;
    @(negedge clk); stop_req = 0; wr_en = 0;
    for (int n = 0; n < 20000 && busy; n++) @(negedge clk);
    @(negedge clk);
    chk(stop_cnt == sc + 1, "R9 stop edge", stop_cnt - sc, 1);
    chk(!busy && !scl_pull && !sda_pull, "R10 idle lines", {busy, scl_pull, sda_pull}, 0);
    chk(irq_cnt - ib == nd + 1, both ? "R9 stop over write" : "R6 irq count", irq_cnt - ib, nd + 1);
    chk(hi_err == he, "R3 high phase", hi_err - he, 0);
    chk(lo_err == le, "R3 low phase", lo_err - le, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      bad++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int sc0;
    void'($urandom(32'h1d2c));
    rst_n = 0; start_req = 0; stop_req = 0; wr_en = 0; wr_data = 0; div = 2;
    repeat (3) @(negedge clk);
    chk(!busy && !scl_pull && !sda_pull && !irq && !ack_det, "R10 reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    sc0 = start_cnt;
    wr_en = 1; wr_data = 8'h00; @(negedge clk); wr_en = 0;
    repeat (10) @(negedge clk);
    chk(!busy && !scl_pull && !sda_pull && start_cnt == sc0, "R8 idle write", busy, 0);
    xfer(8'hA5, 2, 0, 0, 0, 0);
    xfer(8'h3C, 1, 7, 0, 0, 1);
    xfer(8'h80, 2, 3, 1, 0, 0);
    xfer(8'h01, 1, 1, 0, 1, 0);
    xfer(8'hFF, 0, 2, 0, 0, 1);
    for (int t = 0; t < 25; t++)
      xfer(8'($urandom), $urandom % 4, DIV_W'($urandom % 6), $urandom % 4 == 0, $urandom % 4 == 0, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule